// File: doc/BRIEF.md
# Quadrant-Banked Register File

This block holds a set of 32-bit general registers divided into four separate quadrants. Each quadrant owns three read ports and one write port, and it runs with no coupling to the other three. The low two bits of a register number pick its quadrant, so register r sits in quadrant r mod 4 at local slot r / 4. Four consecutively numbered registers therefore fall into four different quadrants. Four operations touching such a run of registers can each be served by their own quadrant in the same cycle. This avoids building one flat array with twelve read and four write ports.

Each quadrant's port group carries full register numbers. A port only serves registers of its own quadrant. An address whose low bits name a different quadrant raises that quadrant's error flag. A write with such an address is dropped, and a read with such an address returns zero. Writes take effect at the clock edge. Reads are combinational. A read of the slot being written in the same cycle returns the incoming data.

Top module: `qrf_quad_file`

## Requirements
- R1: After reset every register reads as zero on every port.
- R2: A write on quadrant q's port to register r, where r mod 4 = q and wr_en is 1, makes r read back that data on any read port of quadrant q from the next cycle on.
- R3: All four quadrants accept a write in the same cycle, for example to registers 8, 9, 10 and 11. Each write lands only in its own register.
- R4: The three read ports of one quadrant return three different registers in the same cycle.
- R5: When a read port addresses the register that its quadrant writes in the same cycle, it returns the new write data in that cycle.
- R6: A write whose address low bits differ from the quadrant number sets that quadrant's addr_err_o bit in the same cycle. It changes no register, neither in its own quadrant nor in the named one.
- R7: A read whose address low bits differ from the quadrant number sets that quadrant's addr_err_o bit and returns zero on that port.
- R8: With wr_en low, the write address and data have no effect on registers, and a mismatched write address raises no error.
- R9: When every read address and every enabled write address of a quadrant matches that quadrant, its addr_err_o bit is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears all registers |
| rd_addr_i | input | 84 | Read register numbers. Quadrant q, port p at bits [(q*3+p)*7 +: 7] |
| rd_data_o | output | 384 | Read data. Quadrant q, port p at bits [(q*3+p)*32 +: 32] |
| wr_en_i | input | 4 | Write enable, one bit per quadrant |
| wr_addr_i | input | 28 | Write register number. Quadrant q at bits [q*7 +: 7] |
| wr_data_i | input | 128 | Write data. Quadrant q at bits [q*32 +: 32] |
| addr_err_o | output | 4 | Bit q is high when a port of quadrant q names a foreign register |

## Verification
The bench builds the block with its default parameters. These are four quadrants of 32 registers of 32 bits, three read ports per quadrant, and write-through enabled. At this size every quadrant can be written in one cycle and all three read ports of a quadrant can be driven at once. The bypass path is also in play. A misrouted address that would alias onto a real slot of the wrong quadrant can be tried directly, because register 9 sent to quadrant 0 would land on slot 2, which holds register 8.

// File: rtl/qrf_pkg.sv
package qrf_pkg;
   localparam int QRF_DATA_W     = 32;
   localparam int QRF_QUADS      = 4;
   localparam int QRF_REGS_PER_Q = 32;
   localparam int QRF_RD_PORTS   = 3;

   // returns 1 when n is a power of two not below 2
   function automatic bit qrf_is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/qrf_addr_check.sv
module qrf_addr_check #(
   parameter int QSEL_W = 2,
   parameter int IDX_W  = 5,
   parameter int QUAD   = 0,
   parameter int NRP    = 3,
   localparam int AW    = QSEL_W + IDX_W
) (
   input  logic [NRP*AW-1:0]    rd_addr_i,
   input  logic                 wr_en_i,
   input  logic [AW-1:0]        wr_addr_i,
   output logic [NRP-1:0]       rd_bad_o,
   output logic [NRP*IDX_W-1:0] rd_idx_o,
   output logic                 wr_bad_o,
   output logic [IDX_W-1:0]     wr_idx_o,
   output logic                 err_o
);
   localparam logic [QSEL_W-1:0] QID = QSEL_W'(QUAD);

   for (genvar p = 0; p < NRP; p++) begin : g_rd
      assign rd_bad_o[p] = rd_addr_i[p*AW +: QSEL_W] != QID;
      assign rd_idx_o[p*IDX_W +: IDX_W] = rd_addr_i[p*AW + QSEL_W +: IDX_W];
   end

   assign wr_bad_o = wr_addr_i[QSEL_W-1:0] != QID;
   assign wr_idx_o = wr_addr_i[AW-1:QSEL_W];
   assign err_o    = (|rd_bad_o) | (wr_en_i & wr_bad_o);
endmodule

// File: rtl/qrf_bank.sv
module qrf_bank #(
   parameter int DW     = 32,
   parameter int IDX_W  = 5,
   parameter int NRP    = 3,
   parameter bit BYPASS = 1'b1,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we_i,
   input  logic [IDX_W-1:0]     wr_idx_i,
   input  logic [DW-1:0]        wr_data_i,
   input  logic [NRP*IDX_W-1:0] rd_idx_i,
   output logic [NRP*DW-1:0]    rd_data_o
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we_i) begin
         mem[wr_idx_i] <= wr_data_i;
      end
   end

   for (genvar p = 0; p < NRP; p++) begin : g_rp
      logic [IDX_W-1:0] ridx;
      assign ridx = rd_idx_i[p*IDX_W +: IDX_W];

      if (BYPASS) begin : g_thru
         assign rd_data_o[p*DW +: DW] = (we_i && ridx == wr_idx_i) ? wr_data_i : mem[ridx];
      end else begin : g_plain
         assign rd_data_o[p*DW +: DW] = mem[ridx];
      end

      // a written slot holds its data while nothing rewrites it
      AST_WR_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
         we_i |=> (ridx != $past(wr_idx_i)) || we_i || (rd_data_o[p*DW +: DW] == $past(wr_data_i))); // R2
   end
endmodule

// File: rtl/qrf_quad_file.sv
module qrf_quad_file
   import qrf_pkg::*;
#(
   parameter int DATA_W     = QRF_DATA_W,
   parameter int QUADS      = QRF_QUADS,
   parameter int REGS_PER_Q = QRF_REGS_PER_Q,
   parameter int RD_PORTS   = QRF_RD_PORTS,
   parameter bit WR_THROUGH = 1'b1,
   localparam int QSEL_W    = $clog2(QUADS),
   localparam int IDX_W     = $clog2(REGS_PER_Q),
   localparam int AW        = QSEL_W + IDX_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [QUADS*RD_PORTS*AW-1:0] rd_addr_i,
   output logic [QUADS*RD_PORTS*DATA_W-1:0] rd_data_o,
   input  logic [QUADS-1:0]             wr_en_i,
   input  logic [QUADS*AW-1:0]          wr_addr_i,
   input  logic [QUADS*DATA_W-1:0]      wr_data_i,
   output logic [QUADS-1:0]             addr_err_o
);
   if (!qrf_is_pow2(QUADS)) begin : g_bad_quads
      $error("QUADS must be a power of two, at least 2");
   end
   if (!qrf_is_pow2(REGS_PER_Q)) begin : g_bad_depth
      $error("REGS_PER_Q must be a power of two, at least 2");
   end
   if (RD_PORTS < 1 || DATA_W < 1) begin : g_bad_ports
      $error("RD_PORTS and DATA_W must be positive");
   end

   logic [QUADS-1:0] bank_we;

   for (genvar q = 0; q < QUADS; q++) begin : g_quad
      localparam logic [QSEL_W-1:0] QID = QSEL_W'(q);

      logic [RD_PORTS-1:0]       rd_bad;
      logic [RD_PORTS*IDX_W-1:0] rd_idx;
      logic                      wr_bad;
      logic [IDX_W-1:0]          wr_idx;
      logic [RD_PORTS*DATA_W-1:0] bank_rd;

      qrf_addr_check #(
         .QSEL_W(QSEL_W), .IDX_W(IDX_W), .QUAD(q), .NRP(RD_PORTS)
      ) i_chk (
         .rd_addr_i (rd_addr_i[q*RD_PORTS*AW +: RD_PORTS*AW]),
         .wr_en_i   (wr_en_i[q]),
         .wr_addr_i (wr_addr_i[q*AW +: AW]),
         .rd_bad_o  (rd_bad),
         .rd_idx_o  (rd_idx),
         .wr_bad_o  (wr_bad),
         .wr_idx_o  (wr_idx),
         .err_o     (addr_err_o[q])
      );

      assign bank_we[q] = wr_en_i[q] & ~wr_bad;

      qrf_bank #(
         .DW(DATA_W), .IDX_W(IDX_W), .NRP(RD_PORTS), .BYPASS(WR_THROUGH)
      ) i_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .we_i      (bank_we[q]),
         .wr_idx_i  (wr_idx),
         .wr_data_i (wr_data_i[q*DATA_W +: DATA_W]),
         .rd_idx_i  (rd_idx),
         .rd_data_o (bank_rd)
      );

      for (genvar p = 0; p < RD_PORTS; p++) begin : g_out
         localparam int SLOT = q*RD_PORTS + p;
         assign rd_data_o[SLOT*DATA_W +: DATA_W] =
            rd_bad[p] ? '0 : bank_rd[p*DATA_W +: DATA_W];

         AST_FOREIGN_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_addr_i[SLOT*AW +: QSEL_W] != QID) |-> (rd_data_o[SLOT*DATA_W +: DATA_W] == '0)); // R7
         AST_FOREIGN_READ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_addr_i[SLOT*AW +: QSEL_W] != QID) |-> addr_err_o[q]); // R7
      end

      AST_FOREIGN_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en_i[q] && wr_addr_i[q*AW +: QSEL_W] != QID) |-> !bank_we[q]); // R6
      AST_FOREIGN_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en_i[q] && wr_addr_i[q*AW +: QSEL_W] != QID) |-> addr_err_o[q]); // R6
      AST_IDLE_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_en_i[q] |-> !bank_we[q]); // R8
   end
endmodule

// File: tb/test_qrf_quad_file.sv
`timescale 1ns/1ps
module test_qrf_quad_file;
   localparam int DW = 32, NQ = 4, NRP = 3, AW = 7, NREG = 128;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NQ*NRP*AW-1:0] rd_addr;
   logic [NQ*NRP*DW-1:0] rd_data;
   logic [NQ-1:0]        wr_en;
   logic [NQ*AW-1:0]     wr_addr;
   logic [NQ*DW-1:0]     wr_data;
   logic [NQ-1:0]        addr_err;

   int total = 0;
   int bad = 0;
   logic [DW-1:0] model [NREG];

   always #5 clk = ~clk;

   qrf_quad_file i_qrf_quad_file (
      .clk(clk), .rst_n(rst_n),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .addr_err_o(addr_err)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      wr_en = '0;
      for (int q = 0; q < NQ; q++) begin
         wr_addr[q*AW +: AW] = AW'(q);
         wr_data[q*DW +: DW] = '0;
         for (int p = 0; p < NRP; p++) rd_addr[(q*NRP+p)*AW +: AW] = AW'(q);
      end
   endtask

   task automatic set_rd(input int q, input int p, input int a);
      rd_addr[(q*NRP+p)*AW +: AW] = AW'(a);
   endtask

   task automatic set_wr(input int q, input int a, input logic [DW-1:0] d);
      wr_en[q] = 1'b1;
      wr_addr[q*AW +: AW] = AW'(a);
      wr_data[q*DW +: DW] = d;
   endtask

   function automatic logic [DW-1:0] rd(input int q, input int p);
      return rd_data[(q*NRP+p)*DW +: DW];
   endfunction

   task automatic t_reset();
      @(negedge clk); idle();
      for (int q = 0; q < NQ; q++)
         for (int p = 0; p < NRP; p++) set_rd(q, p, q + 4*(p*9 + 3));
      #1;
      for (int q = 0; q < NQ; q++)
         for (int p = 0; p < NRP; p++) chk("R1 reset value", rd(q, p), '0);
      chk("R9 no error on valid reads", 32'(addr_err), 32'h0);
   endtask

   task automatic t_adjacent();
      @(negedge clk); idle();
      for (int q = 0; q < NQ; q++) set_wr(q, 8 + q, 32'hA5000000 + 32'(q*4369));
      #1 chk("R9 no error on valid writes", 32'(addr_err), 32'h0);
      @(posedge clk);
      for (int q = 0; q < NQ; q++) model[8+q] = 32'hA5000000 + 32'(q*4369);
      @(negedge clk); idle();
      for (int q = 0; q < NQ; q++) set_rd(q, 0, 8 + q);
      #1;
      for (int q = 0; q < NQ; q++) chk("R3 parallel adjacent write", rd(q, 0), model[8+q]);
   endtask

   task automatic t_three_reads();
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); idle();
         set_wr(1, 1 + 4*k, 32'h1000_0000 * 32'(k+1) + 32'h77);
         @(posedge clk);
         model[1+4*k] = 32'h1000_0000 * 32'(k+1) + 32'h77;
      end
      @(negedge clk); idle();
      set_rd(1, 0, 9); set_rd(1, 1, 1); set_rd(1, 2, 5);
      #1;
      chk("R4 port0", rd(1, 0), model[9]);
      chk("R4 port1", rd(1, 1), model[1]);
      chk("R2 read back next cycle", rd(1, 2), model[5]);
   endtask

   task automatic t_bypass();
      @(negedge clk); idle();
      set_wr(2, 14, 32'hDEADBEEF);
      set_rd(2, 0, 14); set_rd(2, 1, 10);
      #1;
      chk("R5 write-through same cycle", rd(2, 0), 32'hDEADBEEF);
      chk("R5 other slot unaffected", rd(2, 1), model[10]);
      @(posedge clk);
      model[14] = 32'hDEADBEEF;
      @(negedge clk); idle();
      set_rd(2, 2, 14);
      #1 chk("R2 value held after write", rd(2, 2), model[14]);
   endtask

   task automatic t_bad_write();
      @(negedge clk); idle();
      set_wr(0, 9, 32'h0BAD0BAD);   // register 9 belongs to quadrant 1
      #1;
      chk("R6 error flag on foreign write", 32'(addr_err), 32'h1);
      @(posedge clk);
      @(negedge clk); idle();
      set_rd(0, 0, 8); set_rd(1, 0, 9);
      #1;
      chk("R6 own slot untouched", rd(0, 0), model[8]);
      chk("R6 named register untouched", rd(1, 0), model[9]);
   endtask

   task automatic t_bad_read();
      @(negedge clk); idle();
      set_rd(3, 1, 8);   // register 8 belongs to quadrant 0
      #1;
      chk("R7 error flag on foreign read", 32'(addr_err), 32'h8);
      chk("R7 foreign read returns zero", rd(3, 1), '0);
   endtask

   task automatic t_wr_disabled();
      @(negedge clk); idle();
      wr_addr[1*AW +: AW] = AW'(5);  wr_data[1*DW +: DW] = 32'hFFFF0000;
      wr_addr[2*AW +: AW] = AW'(3);  wr_data[2*DW +: DW] = 32'h12345678;
      #1 chk("R8 no error with enable low", 32'(addr_err), 32'h0);
      @(posedge clk);
      @(negedge clk); idle();
      set_rd(1, 0, 5); set_rd(2, 0, 2); set_rd(3, 0, 3);
      #1;
      chk("R8 register 5 unchanged", rd(1, 0), model[5]);
      chk("R8 register 2 unchanged", rd(2, 0), model[2]);
      chk("R8 register 3 unchanged", rd(3, 0), model[3]);
   endtask

   initial begin
      #2000000;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < NREG; i++) model[i] = '0;
      idle();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_adjacent();
      t_three_reads();
      t_bypass();
      t_bad_write();
      t_bad_read();
      t_wr_disabled();
      @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule